// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block is the integer multiply-accumulate engine of a 64-bit processor datapath. It owns a pair of 64-bit accumulator registers, HI and LO, and carries out one accumulate operation per start strobe. The operation is chosen by a 6-bit function code and a 5-bit sub-operation field. Each operation multiplies the low 32 bits of two 64-bit source operands into a 64-bit product. It adds that product to the accumulator and returns a 64-bit result for the destination register.

Under the narrow function code, the accumulator is a 64-bit value. Its upper half comes from bits 31:0 of HI and its lower half from bits 31:0 of LO. Three bits of the sub-operation select, each on its own, unsigned arithmetic, clamped accumulation, and which half of the accumulator is returned. Under the wide function code, the product is added to the whole of LO and HI is not touched. The decoder keeps both function codes and rejects any sub-operation it does not recognise.

Top module: `mac_sat_unit`

## Requirements
- R1: A synchronous active-high reset sets hi_q, lo_q and wb_data to zero and holds wb_valid low.
- R2: Function code 6'b101000 with sub-operation 5'b00000 forms A = {hi_q[31:0], lo_q[31:0]}. It adds the signed 64-bit product of src_a[31:0] and src_b[31:0] modulo 2^64, then writes the new A[63:32] to hi_q[31:0] and the new A[31:0] to lo_q[31:0]. hi_q[63:32] and lo_q[63:32] keep their values.
- R3: Sub-operation bit 0 set selects an unsigned product of the two low source words. Bit 0 clear selects a signed product.
- R4: Under function code 6'b101000, wb_data is a half of the new A sign-extended to 64 bits. It is A[63:32] when sub-operation bit 3 is set and A[31:0] when bit 3 is clear.
- R5: Sub-operation bit 4 set with bit 0 clear selects signed saturation, applied to the exact signed sum. Any negative sum becomes 64'hFFFFFFFF80000000. A sum above 64'h000000007FFFFFFF becomes 64'h000000007FFFFFFF. Any other sum is kept.
- R6: Sub-operation bit 4 set with bit 0 set selects unsigned saturation. An exact unsigned sum above 64'h000000007FFFFFFF becomes 64'hFFFFFFFFFFFFFFFF.
- R7: Function code 6'b101001 adds the product to the whole 64-bit lo_q. It writes the new lo_q to wb_data and leaves hi_q unchanged. Bits 0 and 4 of the sub-operation keep their meaning from R3, R5 and R6.
- R8: Several cases are unrecognised and must cause no write-back and no change to hi_q or lo_q. These are any other function code, sub-operation bits 2:1 not zero under 6'b101000, and sub-operation bits 3:1 not zero under 6'b101001.
- R9: A recognised operation raises wb_valid for exactly one cycle, on the cycle after the start strobe. hi_q and lo_q show their new values in that same cycle. wb_data holds its value between write-backs. Bits 63:32 of the sources have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches one operation |
| func | input | 6 | Function code: narrow or wide accumulate |
| subop | input | 5 | Sub-operation: unsigned, high-half select, saturate |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| wb_data | output | 64 | Destination write-back value |
| wb_valid | output | 1 | One-cycle write-back strobe |
| hi_q | output | 64 | HI accumulator register |
| lo_q | output | 64 | LO accumulator register |

## Verification
Some properties are checked by assertions on every cycle. Without a start, the write-back strobe stays low and the accumulators hold. The upper half of HI never moves, and a wide operation leaves HI alone. A narrow write-back always comes out sign-extended. The arithmetic cannot be shown that way: the product, the clamp limits, the choice of half and the wrap-around in plain mode. The bench's reference model shows these cycle by cycle. It runs directed operands at the clamp limits, negative sums and all-ones words, together with long mixed sequences that include rejected codes and junk in the upper source bits.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
   localparam logic [5:0] FN_NARROW = 6'b101000;
   localparam logic [5:0] FN_WIDE   = 6'b101001;

   // sub-operation bit roles
   localparam int SB_UNS = 0;
   localparam int SB_HI  = 3;
   localparam int SB_SAT = 4;

   typedef struct packed {
      logic ok;
      logic uns;
      logic sat;
      logic hi_sel;
      logic wide;
   } mac_op_t;
endpackage

// File: rtl/mac_op_decode.sv
module mac_op_decode
   import mac_sat_pkg::*;
(
   input  logic [5:0] func,
   input  logic [4:0] subop,
   output mac_op_t    op
);
   logic narrow_ok, wide_ok;

   always_comb begin
      narrow_ok = (func == FN_NARROW) && (subop[2:1] == 2'b00);
      wide_ok   = (func == FN_WIDE)   && (subop[3:1] == 3'b000);
      op.ok     = narrow_ok || wide_ok;
      op.uns    = subop[SB_UNS];
      op.sat    = subop[SB_SAT];
      op.hi_sel = subop[SB_HI] && narrow_ok;
      op.wide   = wide_ok;
   end
endmodule

// File: rtl/mac_product.sv
module mac_product #(
   parameter int HALF_W = 32,
   parameter int REG_W  = 64
) (
   input  logic [HALF_W-1:0] a,
   input  logic [HALF_W-1:0] b,
   input  logic              uns,
   output logic [REG_W-1:0]  prod
);
   localparam int EXT_W = REG_W - HALF_W;

   generate
      if (EXT_W < HALF_W) begin : g_bad_width
         $error("mac_product: REG_W must be at least twice HALF_W");
      end
   endgenerate

   logic [REG_W-1:0] ext_a, ext_b;

   always_comb begin
      ext_a = {{EXT_W{~uns & a[HALF_W-1]}}, a};
      ext_b = {{EXT_W{~uns & b[HALF_W-1]}}, b};
      // low REG_W bits of the extended product equal the exact product
      prod  = ext_a * ext_b;
   end
endmodule

// File: rtl/mac_sat_add.sv
module mac_sat_add #(
   parameter int HALF_W = 32,
   parameter int REG_W  = 64
) (
   input  logic [REG_W-1:0] base,
   input  logic [REG_W-1:0] addend,
   input  logic             uns,
   input  logic             sat,
   output logic [REG_W-1:0] result
);
   localparam int SUM_W = REG_W + 1;
   localparam logic [SUM_W-1:0] POS_LIM_X = SUM_W'({(HALF_W-1){1'b1}});
   localparam logic [REG_W-1:0] POS_LIM   = REG_W'({(HALF_W-1){1'b1}});
   localparam logic [REG_W-1:0] NEG_LIM   = ~POS_LIM;

   logic [SUM_W-1:0] sum;
   logic             neg, above;

   always_comb begin
      sum   = {~uns & base[REG_W-1], base} + {~uns & addend[REG_W-1], addend};
      neg   = ~uns & sum[REG_W];
      above = ~neg & (sum > POS_LIM_X);
      if (!sat)
         result = sum[REG_W-1:0];
      else if (neg)
         result = NEG_LIM;
      else if (above)
         result = uns ? '1 : POS_LIM;
      else
         result = sum[REG_W-1:0];
   end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
   import mac_sat_pkg::*;
#(
   parameter int HALF_W = 32,
   parameter int REG_W  = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [5:0]       func,
   input  logic [4:0]       subop,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   output logic [REG_W-1:0] wb_data,
   output logic             wb_valid,
   output logic [REG_W-1:0] hi_q,
   output logic [REG_W-1:0] lo_q
);
   localparam int UP_W = REG_W - HALF_W;

   generate
      if (REG_W != 2 * HALF_W) begin : g_bad_cfg
         $error("mac_sat_unit: REG_W must equal 2*HALF_W");
      end
   endgenerate

   mac_op_t          op;
   logic [REG_W-1:0] prod, base, res, wb_next;
   logic             narrow_q;

   mac_op_decode u_dec (.func(func), .subop(subop), .op(op));

   mac_product #(.HALF_W(HALF_W), .REG_W(REG_W)) u_mul (
      .a(src_a[HALF_W-1:0]), .b(src_b[HALF_W-1:0]), .uns(op.uns), .prod(prod)
   );

   always_comb begin
      base = op.wide ? lo_q : {hi_q[HALF_W-1:0], lo_q[HALF_W-1:0]};
   end

   mac_sat_add #(.HALF_W(HALF_W), .REG_W(REG_W)) u_add (
      .base(base), .addend(prod), .uns(op.uns), .sat(op.sat), .result(res)
   );

   always_comb begin
      if (op.wide)
         wb_next = res;
      else if (op.hi_sel)
         wb_next = {{UP_W{res[REG_W-1]}}, res[REG_W-1:HALF_W]};
      else
         wb_next = {{UP_W{res[HALF_W-1]}}, res[HALF_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q     <= '0;
         lo_q     <= '0;
         wb_data  <= '0;
         wb_valid <= 1'b0;
         narrow_q <= 1'b0;
      end else begin
         wb_valid <= start & op.ok;
         if (start && op.ok) begin
            wb_data  <= wb_next;
            narrow_q <= ~op.wide;
            if (op.wide) begin
               lo_q <= res;
            end else begin
               hi_q[HALF_W-1:0] <= res[REG_W-1:HALF_W];
               lo_q[HALF_W-1:0] <= res[HALF_W-1:0];
            end
         end
      end
   end

   AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (rst)
      !start |=> !wb_valid); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !start |=> ($stable(hi_q) && $stable(lo_q))); // R8
   AST_HI_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
      start |=> $stable(hi_q[REG_W-1:HALF_W])); // R2
   AST_WIDE_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
      (start && op.wide) |=> $stable(hi_q)); // R7
   AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (start && !op.ok) |=> (!wb_valid && $stable(hi_q) && $stable(lo_q))); // R8
   AST_WB_SEXT: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && narrow_q) |-> (wb_data[REG_W-1:HALF_W] == {UP_W{wb_data[HALF_W-1]}})); // R4
endmodule

// File: tb/mac_sat_unit_tb_top.sv
module mac_sat_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [5:0]  func = '0;
   logic [4:0]  subop = '0;
   logic [63:0] src_a = '0, src_b = '0;
   logic [63:0] wb_data, hi_q, lo_q;
   logic        wb_valid;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 0;

   always #10 clk = ~clk; // 50 MHz

   mac_sat_unit dut_i (
      .clk(clk), .rst(rst), .start(start), .func(func), .subop(subop),
      .src_a(src_a), .src_b(src_b), .wb_data(wb_data), .wb_valid(wb_valid),
      .hi_q(hi_q), .lo_q(lo_q)
   );

   // behavioural reference model
   logic [63:0] e_hi = '0, e_lo = '0, e_wb = '0;
   logic        e_v = 1'b0;
   string       tag = "R1";

   always @(posedge clk) begin
      logic signed [127:0] ex;
      logic [63:0] p, base, r;
      logic ok;
      if (rst) begin
         e_hi = '0; e_lo = '0; e_wb = '0; e_v = 1'b0; tag = "R1";
      end else begin
         e_v = 1'b0; tag = "R9";
         if (start) begin
            ok = (func == 6'h28 && subop[2:1] == 2'b00) ||
                 (func == 6'h29 && subop[3:1] == 3'b000);
            if (!ok) tag = "R8";
            else begin
               if (subop[0]) p = {32'd0, src_a[31:0]} * {32'd0, src_b[31:0]};
               else p = longint'($signed(src_a[31:0])) * longint'($signed(src_b[31:0]));
               base = (func == 6'h29) ? e_lo : {e_hi[31:0], e_lo[31:0]};
               if (subop[0]) ex = {64'd0, base} + {64'd0, p};
               else ex = {{64{base[63]}}, base} + {{64{p[63]}}, p};
               r = ex[63:0];
               if (subop[4]) begin
                  if (subop[0]) begin
                     if (ex > 128'sh7FFFFFFF) r = '1;
                     tag = "R6";
                  end else begin
                     if (ex < 0) r = 64'hFFFFFFFF80000000;
                     else if (ex > 128'sh7FFFFFFF) r = 64'h000000007FFFFFFF;
                     tag = "R5";
                  end
               end else if (subop[0]) tag = "R3";
               else tag = "R2";
               e_v = 1'b1;
               if (func == 6'h29) begin
                  e_lo = r; e_wb = r; tag = "R7";
               end else begin
                  e_hi[31:0] = r[63:32];
                  e_lo[31:0] = r[31:0];
                  if (subop[3]) begin
                     e_wb = {{32{r[63]}}, r[63:32]};
                     if (!subop[4]) tag = "R4";
                  end else e_wb = {{32{r[31]}}, r[31:0]};
               end
            end
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk(tag, "hi_q", hi_q, e_hi);
         chk(tag, "lo_q", lo_q, e_lo);
         chk(tag, "wb_valid", 64'(wb_valid), 64'(e_v));
         chk(tag, "wb_data", wb_data, e_wb);
      end
   end

   task automatic issue(input logic [5:0] f, input logic [4:0] s,
                        input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      func = f; subop = s; src_a = a; src_b = b; start = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
         src_a = {$urandom, $urandom};
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset hi", hi_q, 64'h0);
      chk("R1", "reset wb_valid", 64'(wb_valid), 64'h0);
      rst = 1'b0;
      // R2 directed: 3 * -2 with junk in upper source bits
      issue(6'h28, 5'b00000, 64'hDEAD_0000_0000_0003, 64'hBEEF_0000_FFFF_FFFE);
      idle(1);
      chk("R2", "acc lo", lo_q, 64'h0000_0000_FFFF_FFFA);
      chk("R2", "acc hi", hi_q, 64'h0000_0000_FFFF_FFFF);
      chk("R4", "wb sext", wb_data, 64'hFFFF_FFFF_FFFF_FFFA);
      // R4 high half; R3 unsigned all-ones words
      issue(6'h28, 5'b01000, 64'h5, 64'h7);
      issue(6'h28, 5'b01001, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
      issue(6'h28, 5'b00001, 64'hFFFF_FFFF, 64'h2);
      idle(2);
      // R5 signed saturation high and negative; R6 unsigned
      rst = 1'b1; idle(1); rst = 1'b0;
      issue(6'h28, 5'b10000, 64'h7FFF_FFFF, 64'h7FFF_FFFF);
      issue(6'h28, 5'b11000, 64'h1, 64'h1);
      issue(6'h28, 5'b10000, 64'hFFFF_FFFF, 64'h1);
      issue(6'h28, 5'b10001, 64'h1, 64'h7FFF_FFFE);
      issue(6'h28, 5'b10001, 64'h1, 64'h1);
      issue(6'h28, 5'b11001, 64'h0, 64'h0);
      idle(1);
      // R7 wide variants, R8 rejected codes
      issue(6'h29, 5'b00000, 64'h8000_0000, 64'h8000_0000);
      issue(6'h29, 5'b00001, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
      issue(6'h29, 5'b10000, 64'h3, 64'h3);
      issue(6'h29, 5'b10001, 64'h3, 64'h3);
      issue(6'h29, 5'b01000, 64'h3, 64'h3);
      issue(6'h28, 5'b00010, 64'h3, 64'h3);
      issue(6'h2A, 5'b00000, 64'h3, 64'h3);
      issue(6'h28, 5'b00100, 64'h3, 64'h3);
      idle(2);
      // mixed sequences, R9 timing with gaps and back-to-back
      for (int k = 0; k < 2000; k++) begin
         logic [5:0] f;
         logic [4:0] s;
         int sel;
         sel = int'($urandom_range(0, 9));
         f = (sel < 5) ? 6'h28 : (sel < 9) ? 6'h29 : 6'(($urandom & 32'h3F));
         s = 5'($urandom);
         if ($urandom_range(0, 3) != 0) s[2:1] = 2'b00;
         if (f == 6'h29 && $urandom_range(0, 3) != 0) s[3] = 1'b0;
         if ($urandom_range(0, 9) == 0) begin
            rst = 1'b1; idle(1); rst = 1'b0;
         end
         issue(f, s, {$urandom, $urandom},
               ($urandom_range(0, 3) == 0) ? {$urandom, 32'h7FFF_FFFF} : {$urandom, $urandom});
         if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)));
      end
      idle(3);
      finish_run();
   end
endmodule